// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Status Flags

This block is the purely combinational execute stage of a small 8-bit microcontroller core. It receives an operation code, two 8-bit operands and the core's current 8-bit status word. In the same cycle it returns an 8-bit result, the next status word and a write-enable bit that tells the register file whether the result should be stored. Operand fetch, instruction decode and memory access belong to the surrounding core.

The status word holds, from bit 7 down to bit 0: interrupt enable (I), transfer bit (T), half carry (H), sign (S), two's-complement overflow (V), negative (N), zero (Z) and carry (C). Each operation family updates its own subset of these flags and leaves the rest unchanged. The two carry-chained subtractions let a multi-byte subtraction or comparison build a single zero flag across all of its bytes: Z stays set only if every byte so far came out zero.

Each add-class, subtract-class, negate, increment and decrement operation goes through one shared adder/subtractor. Its H, C and V flags come from per-bit carry or borrow vectors, which are formed from the two operands and the result.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1, which also adds status bit 0) give result a+b(+C) modulo 256. With carry vector k=(a&b)|(a&~r)|(b&~r): H=k[3] and C=k[7]. V is bit 7 of (a&b&~r)|(~a&~b&r). N is r[7], S=N^V, and Z=(r==0). Status bit positions: C0, Z1, N2, V3, S4, H5, T6, I7.
- R2: Subtract (op 2) and compare (op 4) give a-b modulo 256. With borrow vector k=(~a&b)|(b&r)|(r&~a): H=k[3] and C=k[7]. V is bit 7 of (a&~b&~r)|(~a&b&r). N is r[7], S=N^V, and Z=(r==0).
- R3: Subtract-with-carry (op 3) and compare-with-carry (op 5) also subtract the incoming C. Their H, C, V, N and S follow R2. Z is 1 only when the result is zero and the incoming Z was 1; otherwise Z is 0.
- R4: Compare (op 4) and compare-with-carry (op 5) drive wen_o=0. Every other operation code from 0 to 16 drives wen_o=1. Codes 17 to 31 drive wen_o=0, return operand a as the result and leave the status word unchanged.
- R5: AND (op 6), OR (op 7) and XOR (op 8) of a and b clear V, set N and S to result bit 7 and set Z on a zero result. They leave H and C unchanged.
- R6: One's complement (op 9) returns ~a with the flags of R5, except that C is always set to 1.
- R7: Negate (op 10) returns 0-a. C=1 whenever the result is nonzero. H=(r|a)[3]. V=1 only for result 0x80. N=r[7], S=N^V, and Z=(r==0).
- R8: Increment (op 11) returns a+1 and sets V only for result 0x80. Decrement (op 12) returns a-1 and sets V only for result 0x7F. For both, N=r[7], S=N^V, Z=(r==0), and H and C are unchanged.
- R9: Arithmetic shift right (op 13) keeps bit 7, logical shift right (op 14) inserts 0 and rotate right (op 15) inserts the incoming C into bit 7. For all three: C=a[0], N=r[7], V=N^C, S=N^V, Z=(r==0), and H is unchanged.
- R10: Nibble swap (op 16) returns {a[3:0],a[7:4]} and leaves the whole status word unchanged.
- R11: Bits I and T pass through unchanged for every operation code. Every flag-writing operation (codes 0 to 15) leaves S equal to N^V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code, 0 to 16 defined |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand (register or immediate) |
| sreg_i | input | 8 | Current status word I,T,H,S,V,N,Z,C (bit 7..0) |
| res_o | output | 8 | Operation result |
| sreg_o | output | 8 | Next status word |
| wen_o | output | 1 | Result should be written back |

## Verification
The carry-chained subtraction is the point where two functions meet in one evaluation. The incoming carry changes the arithmetic result, and the incoming zero flag gates the new Z. A zero difference can therefore come either from equal operands with no carry in, or from operands one apart with a carry in. The bench drives both cases with the prior Z set and with it clear, and expects Z to follow the prior Z in every case. The same overlap is exercised on the compare form, which must also hold write-enable low. Negate, increment and decrement at 0x80 and 0x7F, where overflow and sign disagree, are judged against an independent wide-arithmetic model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW   = 8;
  localparam int OPW  = 5;

  // status word bit positions
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
  localparam int FT = 6;
  localparam int FI = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP   = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_ASR = 5'd13, OP_LSR = 5'd14, OP_ROR = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // per-bit carry out of an addition x+y giving r
  function automatic logic [DW-1:0] add_carry_vec(input logic [DW-1:0] x, y, r);
    return (x & y) | (x & ~r) | (y & ~r);
  endfunction

  function automatic logic [DW-1:0] add_ovf_vec(input logic [DW-1:0] x, y, r);
    return (x & y & ~r) | (~x & ~y & r);
  endfunction

  // per-bit borrow out of a subtraction x-y giving r
  function automatic logic [DW-1:0] sub_borrow_vec(input logic [DW-1:0] x, y, r);
    return (~x & y) | (y & r) | (r & ~x);
  endfunction

  function automatic logic [DW-1:0] sub_ovf_vec(input logic [DW-1:0] x, y, r);
    return (x & ~y & ~r) | (~x & y & r);
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   r,
  output logic           h,
  output logic           c,
  output logic           v,
  output logic           zero
);
  localparam int HB = 3;

  logic [W-1:0] x, y, kvec, ovec;
  logic         ci, do_sub;

  always_comb begin
    x      = a;
    y      = b;
    ci     = 1'b0;
    do_sub = 1'b0;
    unique case (op)
      OP_ADC:              ci = cin;
      OP_SUB, OP_CP:       do_sub = 1'b1;
      OP_SBC, OP_CPC:      begin do_sub = 1'b1; ci = cin; end
      OP_NEG:              begin do_sub = 1'b1; x = '0; y = a; end
      OP_INC:              y = W'(1);
      OP_DEC:              begin do_sub = 1'b1; y = W'(1); end
      default:             ;
    endcase
  end

  always_comb begin
    if (do_sub) begin
      r    = x - y - {{(W-1){1'b0}}, ci};
      kvec = sub_borrow_vec(x, y, r);
      ovec = sub_ovf_vec(x, y, r);
    end else begin
      r    = x + y + {{(W-1){1'b0}}, ci};
      kvec = add_carry_vec(x, y, r);
      ovec = add_ovf_vec(x, y, r);
    end
  end

  assign h    = kvec[HB];
  assign c    = kvec[W-1];
  assign v    = ovec[W-1];
  assign zero = (r == '0);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  r
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic          cin,
  output logic [W-1:0]  r,
  output logic          c
);
  logic top_bit;

  always_comb begin
    unique case (op)
      OP_ASR:  top_bit = a[W-1];
      OP_ROR:  top_bit = cin;
      default: top_bit = 1'b0;
    endcase
  end

  assign r = {top_bit, a[W-1:1]};
  assign c = a[0];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [4:0] op_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic [7:0] sreg_i,
  output logic [7:0] res_o,
  output logic [7:0] sreg_o,
  output logic       wen_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // decode classes, brought out for the checker
  logic is_arith, is_logic, is_shift, is_cmp, is_chain, is_swap;
  assign is_cmp   = (op == OP_CP)  || (op == OP_CPC);
  assign is_chain = (op == OP_SBC) || (op == OP_CPC);
  assign is_swap  = (op == OP_SWAP);
  assign is_shift = (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_COM);
  assign is_arith = (op_i <= 5'd5) || (op == OP_NEG) || (op == OP_INC) || (op == OP_DEC);

  logic [DW-1:0] ar_r, lg_r, sh_r;
  logic          ar_h, ar_c, ar_v, ar_zero, sh_c;
  logic          chain_zero;

  alu8_arith #(.W(DW)) u_arith (
    .op(op), .a(a_i), .b(b_i), .cin(sreg_i[FC]),
    .r(ar_r), .h(ar_h), .c(ar_c), .v(ar_v), .zero(ar_zero)
  );

  alu8_logic #(.W(DW)) u_logic (
    .op(op), .a(a_i), .b(b_i), .r(lg_r)
  );

  alu8_shift #(.W(DW)) u_shift (
    .op(op), .a(a_i), .cin(sreg_i[FC]), .r(sh_r), .c(sh_c)
  );

  assign chain_zero = ar_zero & sreg_i[FZ];

  logic [DW-1:0] res;
  logic [7:0]    fl;
  logic          keep_hc;

  assign keep_hc = (op == OP_INC) || (op == OP_DEC);

  always_comb begin
    res   = a_i;
    fl    = sreg_i;
    wen_o = 1'b1;
    if (is_arith) begin
      res   = ar_r;
      if (!keep_hc) begin
        fl[FH] = ar_h;
        fl[FC] = ar_c;
      end
      fl[FV] = ar_v;
      fl[FN] = ar_r[DW-1];
      fl[FS] = ar_r[DW-1] ^ ar_v;
      fl[FZ] = is_chain ? chain_zero : ar_zero;
      if (is_cmp) wen_o = 1'b0;
    end else if (is_logic) begin
      res    = lg_r;
      fl[FV] = 1'b0;
      fl[FN] = lg_r[DW-1];
      fl[FS] = lg_r[DW-1];
      fl[FZ] = (lg_r == '0);
      if (op == OP_COM) fl[FC] = 1'b1;
    end else if (is_shift) begin
      res    = sh_r;
      fl[FC] = sh_c;
      fl[FN] = sh_r[DW-1];
      fl[FV] = sh_r[DW-1] ^ sh_c;
      fl[FS] = sh_c;
      fl[FZ] = (sh_r == '0);
    end else if (is_swap) begin
      res = lg_r;
    end else begin
      wen_o = 1'b0;
    end
  end

  assign res_o  = res;
  assign sreg_o = fl;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
  input logic [4:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] sreg_i,
  input logic [7:0] res_o,
  input logic [7:0] sreg_o,
  input logic       wen_o,
  input logic       chain_zero
);
  always_comb begin
    // R11
    it_pass_chk: assert (sreg_o[7:6] == sreg_i[7:6])
      else $error("I/T bits altered");
    // R11
    sign_rule_chk: assert (!(op_i <= 5'd15) || (sreg_o[4] == (sreg_o[2] ^ sreg_o[3])))
      else $error("S != N^V");
    // R4
    wen_chk: assert (wen_o == ((op_i <= 5'd16) && (op_i != 5'd4) && (op_i != 5'd5)))
      else $error("write enable wrong");
    // R4
    undef_chk: assert (!(op_i > 5'd16) || ((sreg_o == sreg_i) && (res_o == a_i)))
      else $error("undefined code not inert");
    // R10
    swap_chk: assert (!(op_i == 5'd16) || ((sreg_o == sreg_i) && (res_o == {a_i[3:0], a_i[7:4]})))
      else $error("swap wrong");
    // R3
    chain_z_chk: assert (!((op_i == 5'd3) || (op_i == 5'd5)) || (sreg_o[1] == chain_zero))
      else $error("chained Z wrong");
    // R3
    chain_clear_chk: assert (!(((op_i == 5'd3) || (op_i == 5'd5)) && !sreg_i[1]) || !sreg_o[1])
      else $error("chained Z set without prior Z");
    // R5
    logic_hc_chk: assert (!((op_i >= 5'd6) && (op_i <= 5'd8)) ||
                          ((sreg_o[5] == sreg_i[5]) && (sreg_o[0] == sreg_i[0]) && !sreg_o[3]))
      else $error("logic op touched H/C or left V");
  end
endmodule

bind alu8_core alu8_chk i_chk (
  .op_i(op_i), .a_i(a_i), .sreg_i(sreg_i), .res_o(res_o),
  .sreg_o(sreg_o), .wen_o(wen_o), .chain_zero(chain_zero)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0] op;
  logic [7:0] a, b, sreg, res, sreg_out;
  logic       wen;

  alu8_core i_alu8_core (
    .op_i(op), .a_i(a), .b_i(b), .sreg_i(sreg),
    .res_o(res), .sreg_o(sreg_out), .wen_o(wen)
  );

  typedef struct {
    logic [7:0] r;
    logic [7:0] s;
    logic       w;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // independent model: wide integer arithmetic
  task automatic model(input logic [4:0] o, input logic [7:0] x, y, st,
                       output logic [7:0] r, output logic [7:0] s, output logic w);
    int xi, yi, ci, t;
    logic C, Z, N, V, S, H;
    xi = x; yi = y; ci = 0;
    s = st; w = 1'b1; r = x;
    C = st[0]; Z = st[1]; H = st[5];
    case (o)
      5'd0, 5'd1: begin
        if (o == 5'd1) ci = st[0];
        t = xi + yi + ci; r = t[7:0];
        C = (t > 255); H = ((xi % 16) + (yi % 16) + ci) > 15;
        V = (x[7] == y[7]) && (r[7] != x[7]); Z = (r == 0);
      end
      5'd2, 5'd3, 5'd4, 5'd5: begin
        if (o == 5'd3 || o == 5'd5) ci = st[0];
        t = xi - yi - ci; r = t[7:0];
        C = (xi < yi + ci); H = ((xi % 16) < (yi % 16) + ci);
        V = (x[7] != y[7]) && (r[7] != x[7]);
        Z = (o == 5'd3 || o == 5'd5) ? ((r == 0) && st[1]) : (r == 0);
        if (o >= 5'd4) w = 1'b0;
      end
      5'd6, 5'd7, 5'd8, 5'd9: begin
        r = (o == 5'd6) ? (x & y) : (o == 5'd7) ? (x | y) : (o == 5'd8) ? (x ^ y) : (8'hFF - x);
        V = 0; Z = (r == 0);
        if (o == 5'd9) C = 1;
      end
      5'd10: begin
        t = 256 - xi; r = t[7:0];
        C = (x != 0); H = (x[3:0] != 0); V = (x == 8'h80); Z = (r == 0);
      end
      5'd11: begin t = xi + 1; r = t[7:0]; V = (x == 8'h7F); Z = (r == 0); end
      5'd12: begin t = xi + 255; r = t[7:0]; V = (x == 8'h80); Z = (r == 0); end
      5'd13, 5'd14, 5'd15: begin
        t = xi / 2;
        if (o == 5'd13 && x[7]) t = t + 128;
        if (o == 5'd15 && st[0]) t = t + 128;
        r = t[7:0]; C = x[0]; V = r[7] ^ C; Z = (r == 0);
      end
      5'd16: r = {x[3:0], x[7:4]};
      default: w = 1'b0;
    endcase
    if (o <= 5'd15) begin
      N = r[7];
      if (o >= 5'd6 && o <= 5'd9) S = N; else S = N ^ V;
      s = {st[7:6], H, S, V, N, Z, C};
    end
  endtask

  task automatic send(input logic [4:0] o, input logic [7:0] x, y, st, input string tag);
    exp_t it;
    @(posedge clk); #1;
    op = o; a = x; b = y; sreg = st;
    model(o, x, y, st, it.r, it.s, it.w);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare at the falling edge, inputs settled since the rising edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (res !== e.r || sreg_out !== e.s || wen !== e.w) begin
        n_bad++;
        $display("FAIL %s: op=%0d a=%02h b=%02h sreg=%02h got res=%02h sreg=%02h wen=%b exp res=%02h sreg=%02h wen=%b",
                 e.tag, op, a, b, sreg, res, sreg_out, wen, e.r, e.s, e.w);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lcg;
    op = 0; a = 0; b = 0; sreg = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    send(5'd0, 8'h00, 8'h00, 8'h00, "R1 initial zero add");
    // R1
    send(5'd0, 8'h7F, 8'h01, 8'h00, "R1 add overflow");
    send(5'd0, 8'hFF, 8'h01, 8'h00, "R1 add carry");
    send(5'd1, 8'h10, 8'h20, 8'h01, "R1 adc carry in");
    send(5'd1, 8'hFF, 8'h00, 8'h01, "R1 adc wrap");
    // R2
    send(5'd2, 8'h10, 8'h01, 8'h00, "R2 sub half borrow");
    send(5'd2, 8'h00, 8'h01, 8'h00, "R2 sub borrow");
    send(5'd2, 8'h80, 8'h01, 8'h00, "R2 sub overflow");
    send(5'd2, 8'h05, 8'h05, 8'h00, "R2 sub zero");
    // R3
    send(5'd3, 8'h05, 8'h05, 8'h02, "R3 sbc zero keeps Z");
    send(5'd3, 8'h05, 8'h05, 8'h00, "R3 sbc zero no prior Z");
    send(5'd3, 8'h06, 8'h05, 8'h03, "R3 sbc carry zero prior Z");
    send(5'd3, 8'h06, 8'h05, 8'h01, "R3 sbc carry zero no prior Z");
    send(5'd5, 8'h00, 8'h00, 8'h03, "R3 cpc nonzero clears Z");
    send(5'd5, 8'h07, 8'h06, 8'h03, "R3 cpc chained zero");
    // R4
    send(5'd4, 8'h03, 8'h07, 8'h00, "R4 cp no write");
    send(5'd20, 8'h3C, 8'h11, 8'hA5, "R4 undefined code 20");
    send(5'd31, 8'h81, 8'hFF, 8'h5A, "R4 undefined code 31");
    // R5
    send(5'd6, 8'hF0, 8'h0F, 8'h29, "R5 and zero keeps H C");
    send(5'd7, 8'h80, 8'h01, 8'h08, "R5 or negative clears V");
    send(5'd8, 8'hAA, 8'h55, 8'h21, "R5 xor");
    // R6
    send(5'd9, 8'h00, 8'h00, 8'h00, "R6 com of zero");
    send(5'd9, 8'hFF, 8'h00, 8'h20, "R6 com to zero");
    // R7
    send(5'd10, 8'h00, 8'h00, 8'h01, "R7 neg zero");
    send(5'd10, 8'h01, 8'h00, 8'h00, "R7 neg one");
    send(5'd10, 8'h80, 8'h00, 8'h00, "R7 neg 0x80");
    send(5'd10, 8'h10, 8'h00, 8'h00, "R7 neg no half");
    // R8
    send(5'd11, 8'h7F, 8'h00, 8'h21, "R8 inc to 0x80");
    send(5'd11, 8'hFF, 8'h00, 8'h00, "R8 inc wrap");
    send(5'd12, 8'h80, 8'h00, 8'h21, "R8 dec to 0x7F");
    send(5'd12, 8'h01, 8'h00, 8'h00, "R8 dec to zero");
    send(5'd12, 8'h00, 8'h00, 8'h00, "R8 dec wrap");
    // R9
    send(5'd13, 8'h81, 8'h00, 8'h00, "R9 asr");
    send(5'd14, 8'h01, 8'h00, 8'h20, "R9 lsr to zero");
    send(5'd15, 8'h02, 8'h00, 8'h01, "R9 ror carry in");
    send(5'd15, 8'h01, 8'h00, 8'h00, "R9 ror carry out");
    // R10
    send(5'd16, 8'h3C, 8'h99, 8'h5A, "R10 swap");
    // R11
    send(5'd0, 8'h40, 8'h40, 8'hC0, "R11 add keeps I T");
    send(5'd14, 8'h80, 8'h00, 8'h40, "R11 lsr keeps T");
    // mixed sweep over all codes
    lcg = 8'h5B;
    for (int i = 0; i < 640; i++) begin
      logic [7:0] x, y, st;
      lcg = lcg * 8'd37 + 8'd101; x = lcg;
      lcg = lcg * 8'd37 + 8'd101; y = lcg;
      lcg = lcg * 8'd37 + 8'd101; st = lcg;
      send(5'(i % 20), x, y, st, "R11 sweep");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule